// File: doc/BRIEF.md
# Network-Synchronized Time Counter

This block keeps a free-running 16-bit network time count that advances once per resolution tick, the tick coming from an external prescaler. Each node holds a configured master identifier. When that identifier equals the node's own identifier, the node acts as the time master and simply counts. On every other node the count is locked to time words that the master sends.

A slave node takes time words from a receive strobe that carries the sender's identifier. The first word accepted from the master overwrites the local count. The block then stays in tracking mode until a re-arm event: a software reset, a write of the master identifier, or the end of stop mode. In tracking mode every accepted word is compared with the local count. The result either holds back one tick or adds one extra increment, which pulls the local phase toward the master.

An active-low carry line pulses whenever a selectable count bit changes, and each pulse lasts one tick period. So all nodes locked to the same master produce aligned pulses. An 8-bit read port returns the count a byte at a time. Reading the low byte freezes a copy of the high byte, so a 16-bit read is always coherent.

Top module: `net_time_sync`

## Requirements
- R1: After reset the count is 0x0000, `carry_n` is 1, the master identifier register holds the parameter `MID_RST` (0), and the preset is armed.
- R2: Outside stop mode, with no correction pending and no preset, every cycle with `tick_in` high raises the count by one, wrapping from 0xFFFF to 0x0000.
- R3: `is_master` is 1 exactly when the master identifier register equals `node_id`. A master never loads or tracks from received words. A slave accepts a word only when `rx_src` equals the master identifier.
- R4: While armed, an accepted word is copied into the count at the next clock edge and the preset is disarmed. Later accepted words do not overwrite the count.
- R5: The preset is re-armed by a `soft_rst` pulse, by any `mid_wr` write, and by `stop_mode` going from 1 to 0.
- R6: When a word is accepted while disarmed and (local count − received word), taken as a 16-bit two's-complement value, is +2 or more, the next non-stopped tick leaves the count unchanged.
- R7: When that difference is −1 or less, the next non-stopped tick raises the count by two.
- R8: When that difference is 0 or +1, no correction is made. A newly accepted word replaces any correction still pending, so at most one correction is applied per word.
- R9: While `stop_mode` is 1, the count holds, received words are ignored, and `carry_n` returns to 1 at the first tick and stays there.
- R10: `carry_sel` gives the index (0 = least significant) of the count bit to watch. When that bit changes, `carry_n` goes low at the same edge as the count and stays low until the next tick that does not change the bit.
- R11: Read data is combinational. With `rd_addr` 0 it gives count bits 7:0, and a cycle with `rd_en` high and `rd_addr` 0 captures count bits 15:8. With `rd_addr` 1 it gives that captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse; re-arms the preset |
| node_id | input | 8 | This node's identifier |
| mid_wr | input | 1 | Write strobe for the master identifier register |
| mid_wdata | input | 8 | Master identifier write value |
| stop_mode | input | 1 | 1 freezes the count and the carry line |
| tick_in | input | 1 | One-cycle resolution tick from the prescaler |
| carry_sel | input | 4 | Index of the count bit driving the carry pulse |
| rx_valid | input | 1 | Received time word strobe |
| rx_src | input | 8 | Sender identifier of the received word |
| rx_time | input | 16 | Received time word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 = low byte (captures high byte), 1 = captured high byte |
| rd_data | output | 8 | Read data |
| carry_n | output | 1 | Active-low carry pulse |
| is_master | output | 1 | 1 when this node is the time master |

## Verification
The embedded properties assume that `tick_in`, `rx_valid`, `soft_rst` and `mid_wr` are single-cycle strobes. They also assume a preset load never occurs together with stop mode, which the block itself guarantees by gating received words with `stop_mode`. The stimulus changes every input on the falling edge and raises each strobe for exactly one cycle. It keeps received words and ticks in separate cycles, so each correction can be tied to one word and one tick. The tracking table sets up each difference from a known preset value, with no tick in between.

// File: rtl/nts_pkg.sv
package nts_pkg;
   typedef enum logic [1:0] {
      ADJ_NONE = 2'd0,
      ADJ_SLOW = 2'd1,
      ADJ_FAST = 2'd2
   } adj_e;
endpackage

// File: rtl/nts_sync_ctrl.sv
module nts_sync_ctrl
   import nts_pkg::*;
#(
   parameter int          ID_W    = 8,
   parameter int          CNT_W   = 16,
   parameter logic [ID_W-1:0] MID_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             mid_wr,
   input  logic [ID_W-1:0]  mid_wdata,
   input  logic [ID_W-1:0]  node_id,
   input  logic             stop_i,
   input  logic             tick_i,
   input  logic             rx_valid,
   input  logic [ID_W-1:0]  rx_src,
   input  logic [CNT_W-1:0] rx_time,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             is_master,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output adj_e             adj_o
);
   localparam logic signed [CNT_W-1:0] LEAD_MIN = CNT_W'(2);

   logic [ID_W-1:0]         mid_q;
   logic                    stop_q;
   logic                    armed_q;
   adj_e                    adj_q, adj_d;
   logic                    arm_evt;
   logic                    accept;
   logic signed [CNT_W-1:0] phase_diff;
   adj_e                    adj_cls;

   assign is_master  = (mid_q == node_id);
   assign arm_evt    = soft_rst | mid_wr | (stop_q & ~stop_i);
   assign accept     = rx_valid & ~is_master & (rx_src == mid_q) & ~stop_i;
   assign load_o     = accept & armed_q;
   assign load_val_o = rx_time;
   assign phase_diff = $signed(cnt_i - rx_time);
   assign adj_o      = adj_q;

   always_comb begin
      if (phase_diff >= LEAD_MIN)  adj_cls = ADJ_SLOW;
      else if (phase_diff < 0)     adj_cls = ADJ_FAST;
      else                         adj_cls = ADJ_NONE;
   end

   always_comb begin
      adj_d = adj_q;
      if (arm_evt)                 adj_d = ADJ_NONE;
      else if (accept)             adj_d = armed_q ? ADJ_NONE : adj_cls;
      else if (tick_i && !stop_i)  adj_d = ADJ_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_q   <= MID_RST;
         stop_q  <= 1'b0;
         armed_q <= 1'b1;
         adj_q   <= ADJ_NONE;
      end else begin
         if (mid_wr) mid_q <= mid_wdata;
         stop_q <= stop_i;
         adj_q  <= adj_d;
         if (arm_evt)     armed_q <= 1'b1;
         else if (load_o) armed_q <= 1'b0;
      end
   end

   // R4: a preset consumes the arming
   assert_preset_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && !arm_evt) |=> !armed_q)
      else $error("preset did not disarm");

   // R5: every re-arm event leaves the preset armed
   assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arm_evt |=> armed_q)
      else $error("re-arm event lost");

   // R9: stop mode never lets a word through
   assert_stop_deaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |-> !load_o)
      else $error("load while stopped");
endmodule

// File: rtl/nts_counter.sv
module nts_counter
   import nts_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  adj_e             adj_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (load_i) begin
         cnt_d = load_val_i;
      end else if (tick_i && !stop_i) begin
         unique case (adj_i)
            ADJ_SLOW: cnt_d = cnt_q;
            ADJ_FAST: cnt_d = cnt_q + CNT_W'(2);
            default:  cnt_d = cnt_q + CNT_W'(1);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o     = cnt_q;
   assign cnt_nxt_o = cnt_d;

   // R2: plain tick steps by one
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !stop_i && !load_i && adj_i == ADJ_NONE) |=> cnt_q == $past(cnt_q) + CNT_W'(1))
      else $error("plain tick step wrong");

   // R4: preset lands in one edge
   assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == $past(load_val_i))
      else $error("preset value not loaded");

   // R6: slow correction swallows the tick
   assert_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !stop_i && !load_i && adj_i == ADJ_SLOW) |=> $stable(cnt_q))
      else $error("slow correction ignored");

   // R7: fast correction adds an extra count
   assert_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !stop_i && !load_i && adj_i == ADJ_FAST) |=> cnt_q == $past(cnt_q) + CNT_W'(2))
      else $error("fast correction wrong");

   // R9: stop mode freezes the count
   assert_hold_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !load_i) |=> $stable(cnt_q))
      else $error("count moved while stopped");
endmodule

// File: rtl/nts_carry.sv
module nts_carry #(
   parameter int CNT_W = 16,
   parameter int SEL_W = $clog2(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             stop_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   output logic             carry_n
);
   logic [CNT_W-1:0] flip;
   logic             flip_sel;
   logic             act_q;

   for (genvar b = 0; b < CNT_W; b++) begin : g_flip
      assign flip[b] = cnt_nxt_i[b] ^ cnt_i[b];
   end

   assign flip_sel = flip[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_q <= 1'b0;
      else if (flip_sel) act_q <= 1'b1;
      else if (tick_i)   act_q <= 1'b0;
   end

   assign carry_n = ~act_q;

   // R10: pulse level only moves on a tick or a watched-bit change
   assert_carry_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !flip_sel) |=> $stable(carry_n))
      else $error("carry changed between ticks");

   // R9: a tick in stop mode ends any pulse
   assert_carry_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && tick_i) |=> carry_n)
      else $error("carry active while stopped");
endmodule

// File: rtl/nts_rdport.sv
module nts_rdport #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             rd_addr,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [BUS_W-1:0] rd_data
);
   logic [BUS_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hi_q <= '0;
      else if (rd_en && !rd_addr) hi_q <= cnt_i[CNT_W-1:BUS_W];
   end

   assign rd_data = rd_addr ? hi_q : cnt_i[BUS_W-1:0];

   // R11: low-byte read freezes the matching high byte
   assert_hi_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_addr) |=> hi_q == $past(cnt_i[CNT_W-1:BUS_W]))
      else $error("high byte not captured");

   // R11: odd-address reads do not disturb the captured byte
   assert_hi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !rd_addr) |=> $stable(hi_q))
      else $error("captured byte changed");
endmodule

// File: rtl/net_time_sync.sv
module net_time_sync
   import nts_pkg::*;
#(
   parameter int              ID_W    = 8,
   parameter int              BUS_W   = 8,
   parameter int              CNT_W   = 2 * BUS_W,
   parameter int              SEL_W   = $clog2(CNT_W),
   parameter logic [ID_W-1:0] MID_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [ID_W-1:0]  node_id,
   input  logic             mid_wr,
   input  logic [ID_W-1:0]  mid_wdata,
   input  logic             stop_mode,
   input  logic             tick_in,
   input  logic [SEL_W-1:0] carry_sel,
   input  logic             rx_valid,
   input  logic [ID_W-1:0]  rx_src,
   input  logic [CNT_W-1:0] rx_time,
   input  logic             rd_en,
   input  logic             rd_addr,
   output logic [BUS_W-1:0] rd_data,
   output logic             carry_n,
   output logic             is_master
);
   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("count width must be two bus bytes");
   end
   if ((1 << SEL_W) != CNT_W) begin : g_bad_sel
      $error("carry select must span the count exactly");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("identifier width must be positive");
   end

   logic             load;
   logic [CNT_W-1:0] load_val;
   adj_e             adj;
   logic [CNT_W-1:0] cnt, cnt_nxt;

   nts_sync_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W), .MID_RST(MID_RST)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .mid_wr     (mid_wr),
      .mid_wdata  (mid_wdata),
      .node_id    (node_id),
      .stop_i     (stop_mode),
      .tick_i     (tick_in),
      .rx_valid   (rx_valid),
      .rx_src     (rx_src),
      .rx_time    (rx_time),
      .cnt_i      (cnt),
      .is_master  (is_master),
      .load_o     (load),
      .load_val_o (load_val),
      .adj_o      (adj)
   );

   nts_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_in),
      .stop_i     (stop_mode),
      .load_i     (load),
      .load_val_i (load_val),
      .adj_i      (adj),
      .cnt_o      (cnt),
      .cnt_nxt_o  (cnt_nxt)
   );

   nts_carry #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_carry (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_in),
      .stop_i    (stop_mode),
      .sel_i     (carry_sel),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .carry_n   (carry_n)
   );

   nts_rdport #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .cnt_i   (cnt),
      .rd_data (rd_data)
   );

   // R3: a master node never presets from the network
   assert_master_deaf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !tick_in) |=> $stable(cnt))
      else $error("master count disturbed by a word");
endmodule

// File: tb/tb_net_time_sync.sv
module tb_net_time_sync;
   localparam int CLK_P = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [7:0]  node_id = 8'd5;
   logic        mid_wr = 1'b0;
   logic [7:0]  mid_wdata = '0;
   logic        stop_mode = 1'b0;
   logic        tick_in = 1'b0;
   logic [3:0]  carry_sel = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_src = '0;
   logic [15:0] rx_time = '0;
   logic        rd_en = 1'b0;
   logic        rd_addr = 1'b0;
   logic [7:0]  rd_data;
   logic        carry_n;
   logic        is_master;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   net_time_sync dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .node_id(node_id),
      .mid_wr(mid_wr), .mid_wdata(mid_wdata), .stop_mode(stop_mode),
      .tick_in(tick_in), .carry_sel(carry_sel), .rx_valid(rx_valid),
      .rx_src(rx_src), .rx_time(rx_time), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .carry_n(carry_n), .is_master(is_master)
   );

   // preset value, received word, expected count after one tick
   localparam logic [15:0] V_PRE [0:7] = '{16'd100, 16'd100, 16'd100, 16'd100,
                                           16'h0005, 16'hFFFF, 16'h8000, 16'd100};
   localparam logic [15:0] V_RX  [0:7] = '{16'd98,  16'd100, 16'd99,  16'd101,
                                           16'hFFF0, 16'h0003, 16'h0000, 16'd2000};
   localparam logic [15:0] V_EXP [0:7] = '{16'd100, 16'd101, 16'd101, 16'd102,
                                           16'h0005, 16'h0001, 16'h8002, 16'd102};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_in = 1'b1;
         @(negedge clk) tick_in = 1'b0;
      end
   endtask

   task automatic send(input logic [7:0] src, input logic [15:0] val);
      @(negedge clk);
      rx_valid = 1'b1; rx_src = src; rx_time = val;
      @(negedge clk) rx_valid = 1'b0;
   endtask

   task automatic write_mid(input logic [7:0] v);
      @(negedge clk);
      mid_wr = 1'b1; mid_wdata = v;
      @(negedge clk) mid_wr = 1'b0;
   endtask

   task automatic pulse_soft();
      @(negedge clk) soft_rst = 1'b1;
      @(negedge clk) soft_rst = 1'b0;
   endtask

   task automatic set_stop(input logic v);
      @(negedge clk) stop_mode = v;
      @(negedge clk);
   endtask

   task automatic read_cnt(output logic [15:0] v);
      logic [7:0] lo;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 1'b0;
      #1 lo = rd_data;
      @(negedge clk);
      rd_en = 1'b0; rd_addr = 1'b1;
      #1 v = {rd_data, lo};
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] c, c0;
      logic [7:0]  lo;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 carry_n", carry_n, 1);
      check("R1 is_master", is_master, 0);
      read_cnt(c);
      check("R1 count", c, 16'h0000);

      // R2 free running
      tick_n(3);
      read_cnt(c);
      check("R2 three ticks", c, 16'd3);

      // R3 foreign sender ignored while armed (master id reset value is 0)
      write_mid(8'd3);
      send(8'd4, 16'h1234);
      read_cnt(c);
      check("R3 foreign sender", c, 16'd3);
      send(8'd3, 16'h1234);
      read_cnt(c);
      check("R3 master sender preset", c, 16'h1234);

      // R3 master role
      write_mid(8'd5);
      check("R3 is_master", is_master, 1);
      read_cnt(c0);
      send(8'd5, 16'h4444);
      read_cnt(c);
      check("R3 master ignores words", c, c0);
      tick_n(1);
      read_cnt(c);
      check("R2 master counts", c, c0 + 16'd1);
      write_mid(8'd3);
      check("R3 slave again", is_master, 0);

      // tracking table: R4 preset, R4 once, R6/R7/R8 correction
      for (int k = 0; k < 8; k++) begin
         logic signed [15:0] d;
         string tag;
         d = $signed(V_PRE[k] - V_RX[k]);
         tag = (d >= 2) ? "R6" : ((d < 0) ? "R7" : "R8");
         pulse_soft();
         send(8'd3, V_PRE[k]);
         read_cnt(c);
         check("R4 preset after soft reset (R5)", c, V_PRE[k]);
         send(8'd3, V_RX[k]);
         read_cnt(c);
         check("R4 no second preset", c, V_PRE[k]);
         tick_n(1);
         read_cnt(c);
         check(tag, c, V_EXP[k]);
      end

      // R8 newer word replaces pending correction
      pulse_soft();
      send(8'd3, 16'd50);
      send(8'd3, 16'd40);
      send(8'd3, 16'd50);
      tick_n(1);
      read_cnt(c);
      check("R8 replaced correction", c, 16'd51);

      // R5 master-id write re-arms
      write_mid(8'd3);
      send(8'd3, 16'h0ABC);
      read_cnt(c);
      check("R5 mid write re-arms", c, 16'h0ABC);

      // R2 wrap and R10 carry on top bit
      carry_sel = 4'd15;
      write_mid(8'd3);
      send(8'd3, 16'hFFFF);
      tick_n(1);
      read_cnt(c);
      check("R2 wrap", c, 16'h0000);
      check("R10 carry on msb", carry_n, 0);

      // R10 carry width on bit 2
      carry_sel = 4'd2;
      write_mid(8'd3);
      send(8'd3, 16'd3);
      tick_n(1);
      check("R10 carry low after change", carry_n, 0);
      @(negedge clk);
      check("R10 carry held between ticks", carry_n, 0);
      tick_n(1);
      check("R10 carry released", carry_n, 1);

      // R9 stop mode
      carry_sel = 4'd0;
      read_cnt(c0);
      set_stop(1'b1);
      tick_n(1);
      check("R9 no carry while stopped", carry_n, 1);
      tick_n(2);
      check("R9 carry idle", carry_n, 1);
      send(8'd3, 16'h7777);
      read_cnt(c);
      check("R9 count held", c, c0);
      set_stop(1'b0);
      send(8'd3, 16'h2222);
      read_cnt(c);
      check("R5 stop release re-arms", c, 16'h2222);

      // R11 coherent read across a carry into the high byte
      pulse_soft();
      send(8'd3, 16'h12FF);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 1'b0;
      #1 lo = rd_data;
      @(negedge clk);
      rd_en = 1'b0; tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0; rd_addr = 1'b1;
      #1 check("R11 low byte", lo, 8'hFF);
      check("R11 latched high byte", rd_data, 8'h12);
      read_cnt(c);
      check("R11 fresh read", c, 16'h1300);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule